// File: doc/BRIEF.md
# Conversion Request Queue Source

This block is an eight-deep request queue that sits in front of an ADC sequencer's arbiter. Software loads entries through a simple push port. Each entry carries four things:

- a channel number;
- a flag that re-appends the entry after it is served;
- a flag that enables a completion event;
- a flag that holds the entry until an external trigger pulse arrives.

The oldest entry is shown to the arbiter as a pending request once its trigger condition is met and the gate input is open. The arbiter marks the start and the end of each conversion with one-cycle strobes. It may also abort a conversion that is running.

When a conversion ends, the head entry leaves the queue. If its re-append flag is set, the same entry goes back in at the tail in the same cycle. Because of this, a loop of conversions can keep running with no software action. A flush input empties the queue in one cycle.

Top module: `conv_queue_src`

## Requirements
- R1: Entries are served strictly in the order they were pushed. Up to 8 entries are held, and `q_level` reports how many are stored, one cycle after each change.
- R2: Any channel number may be pushed, and the same number may be queued more than once. Each entry is served with exactly the channel it was pushed with.
- R3: A push while `q_level` is 8 is dropped and sets `overflow`. `overflow` stays set until flush or reset.
- R4: If the head entry has its refill bit (`push_refill`=1) set when `conv_done` is strobed, it is written back at the tail in that cycle. `q_level` is unchanged, and the entry is served again after all older entries.
- R5: If the refill bit is clear, `conv_done` removes the head entry and `q_level` falls by one.
- R6: `src_event` is high for exactly the one cycle after `conv_done` when the finished entry had `push_evt_en`=1. It stays low otherwise. `evt_chan` gives that entry's channel.
- R7: A head entry with `push_wait_trig`=1 raises no request until a `trig_in` pulse is seen. The request appears in the cycle after the pulse, and the trigger is consumed when that entry completes.
- R8: A `trig_in` pulse is ignored and not stored when the queue is empty, when the head entry does not wait for a trigger, or while a conversion is running.
- R9: While `gate_en` is 0, `req_valid` is 0. A trigger latched for the head is kept, and the request reappears once the gate opens.
- R10: `conv_start` while `req_valid` is 1 drops `req_valid` from the next cycle until `conv_done` or `conv_abort`. After an abort the same head entry is requested again with no new trigger, and `q_level` is unchanged.
- R11: `flush` empties the queue, clears any latched trigger, ends any running conversion and clears `overflow`, all in one cycle.
- R12: After reset the queue is empty, and `req_valid`, `src_event` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push strobe, one entry per cycle |
| push_chan | input | CH_W | Channel number of the pushed entry |
| push_refill | input | 1 | Re-append the entry after it is served |
| push_evt_en | input | 1 | Raise a source event when the entry finishes |
| push_wait_trig | input | 1 | Hold the entry until a trigger pulse |
| flush | input | 1 | Empty the queue and clear latched state |
| trig_in | input | 1 | External trigger pulse |
| gate_en | input | 1 | Request gate, 1 = open |
| conv_start | input | 1 | Arbiter accepted the pending request |
| conv_done | input | 1 | Running conversion finished |
| conv_abort | input | 1 | Running conversion cancelled |
| req_valid | output | 1 | Head entry is pending to the arbiter |
| req_chan | output | CH_W | Channel of the pending request |
| q_level | output | LVL_W | Number of stored entries |
| overflow | output | 1 | Sticky flag for a dropped push |
| src_event | output | 1 | One-cycle completion event |
| evt_chan | output | CH_W | Channel of the completed entry |

## Verification
The assertions assume that the arbiter behaves. It strobes `conv_start` only while `req_valid` is high. It strobes `conv_done` or `conv_abort` only while a conversion is running, and never both in the same cycle. `flush` is not raised together with a handshake strobe. The directed tasks only drive these strobes at points where those conditions hold, and each task starts from a flushed queue. Trigger and push pulses last exactly one cycle.

// File: rtl/cq_pkg.sv
// Shared types for the conversion request queue.
// Assumes: nothing beyond the fields declared here.
package cq_pkg;

    // Per-entry control bits travelling with each queued channel.
    typedef struct packed {
        logic refill;     // re-append at tail after completion
        logic evt_en;     // raise a source event on completion
        logic wait_trig;  // hold until an external trigger
    } cq_flags_t;

    // Conversion tracking state for the head entry.
    typedef enum logic {
        CQ_IDLE = 1'b0,
        CQ_CONV = 1'b1
    } cq_state_t;

endpackage

// File: rtl/cq_store.sv
// Circular entry storage with one push port and a head re-append port.
// Keeps channel and flags per slot, and tracks level and sticky overflow.
// Assumes: DEPTH is a power of two. pop_en is only raised while the store is
// not empty. reappend is only raised together with pop_en.
module cq_store
    import cq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CH_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push_en,
    input  logic [CH_W-1:0]              push_chan,
    input  cq_flags_t                    push_flags,
    input  logic                         pop_en,
    input  logic                         reappend,
    output logic [CH_W-1:0]              head_chan,
    output cq_flags_t                    head_flags,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [CH_W-1:0] chan_mem  [DEPTH];
    cq_flags_t       flag_mem  [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_ptr_nx1;
    logic             push_ok;
    logic [PTR_W-1:0] push_slot;

    // Push is accepted whenever a slot is free before this cycle.
    assign push_ok    = push_en && (level < LVL_MAX);
    assign wr_ptr_nx1 = wr_ptr + PTR_W'(1);
    // When the head is re-appended it takes the tail slot first.
    assign push_slot  = reappend ? wr_ptr_nx1 : wr_ptr;

    assign head_chan  = chan_mem[rd_ptr];
    assign head_flags = flag_mem[rd_ptr];
    assign empty      = (level == '0);

    // Slot contents: write re-appended head and/or new push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                chan_mem[i] <= '0;
                flag_mem[i] <= '0;
            end
        end else if (!flush) begin
            if (reappend) begin
                chan_mem[wr_ptr] <= chan_mem[rd_ptr];
                flag_mem[wr_ptr] <= flag_mem[rd_ptr];
            end
            if (push_ok) begin
                chan_mem[push_slot] <= push_chan;
                flag_mem[push_slot] <= push_flags;
            end
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            rd_ptr <= rd_ptr + PTR_W'(pop_en);
            wr_ptr <= wr_ptr + PTR_W'(reappend) + PTR_W'(push_ok);
            level  <= level - LVL_W'(pop_en) + LVL_W'(reappend) + LVL_W'(push_ok);
        end
    end

    // Sticky overflow on a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) overflow <= 1'b0;
        else if (push_en && !push_ok) overflow <= 1'b1;
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_MAX && push_en && !flush) |=> overflow);
    assert_refill_keeps_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reappend && !push_en && !flush) |=> $stable(level));
    assert_pop_drops_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !reappend && !push_en && !flush) |=> (level == $past(level) - LVL_W'(1)));
endmodule

// File: rtl/cq_trig.sv
// Trigger latch for the head entry.
// Records one trigger pulse when the head waits for one, and releases it when
// the entry completes or the queue is flushed.
// Assumes: consume marks the completion of the head entry.
module cq_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic trig_in,
    input  logic head_valid,
    input  logic head_wait,
    input  logic busy,
    input  logic consume,
    output logic trig_ok
);
    logic latched;
    logic take;

    // Only a waiting, idle, non-empty head may absorb a trigger.
    assign take    = trig_in && head_valid && head_wait && !busy && !latched;
    assign trig_ok = !head_wait || latched;

    // Latch update: set on an accepted pulse, clear on completion or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) latched <= 1'b0;
        else if (consume)    latched <= 1'b0;
        else if (take)       latched <= 1'b1;
    end

    assert_latch_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> head_valid);
    assert_latch_from_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(trig_in));
endmodule

// File: rtl/cq_ctrl.sv
// Conversion tracker for the head entry.
// Follows the start/done/abort handshake, pops the head on completion and
// produces the one-cycle source event.
// Assumes: conv_done and conv_abort are never raised together.
module cq_ctrl
    import cq_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            req_valid,
    input  logic            conv_start,
    input  logic            conv_done,
    input  logic            conv_abort,
    input  logic            head_evt_en,
    input  logic [CH_W-1:0] head_chan,
    output logic            busy,
    output logic            finish,
    output logic            src_event,
    output logic [CH_W-1:0] evt_chan
);
    cq_state_t state;

    assign busy   = (state == CQ_CONV);
    assign finish = busy && conv_done && !flush;

    // Handshake state: enter on accepted start, leave on done, abort or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                      state <= CQ_IDLE;
        else if (!busy && req_valid && conv_start) state <= CQ_CONV;
        else if (busy && (conv_done || conv_abort)) state <= CQ_IDLE;
    end

    // Completion event, registered one cycle after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_event <= 1'b0;
            evt_chan  <= '0;
        end else begin
            src_event <= finish && head_evt_en;
            if (finish) evt_chan <= head_chan;
        end
    end

    assert_event_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_event |-> $past(conv_done));
    assert_event_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_event |=> !src_event || $past(conv_done));
    assert_start_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && conv_start && !flush) |=> busy);
endmodule

// File: rtl/conv_queue_src.sv
// Conversion request queue source: top level.
// Joins storage, trigger latch and handshake tracker, and forms the request.
// Assumes: the arbiter strobes conv_start only while req_valid is high.
module conv_queue_src
    import cq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CH_W  = 5,
    parameter int LVL_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [CH_W-1:0]  push_chan,
    input  logic             push_refill,
    input  logic             push_evt_en,
    input  logic             push_wait_trig,
    input  logic             flush,
    input  logic             trig_in,
    input  logic             gate_en,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic             conv_abort,
    output logic             req_valid,
    output logic [CH_W-1:0]  req_chan,
    output logic [LVL_W-1:0] q_level,
    output logic             overflow,
    output logic             src_event,
    output logic [CH_W-1:0]  evt_chan
);
    cq_flags_t       push_flags, head_flags;
    logic [CH_W-1:0] head_chan;
    logic            empty, busy, finish, trig_ok;

    assign push_flags = '{refill: push_refill, evt_en: push_evt_en, wait_trig: push_wait_trig};

    cq_store #(.DEPTH(DEPTH), .CH_W(CH_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_en    (push_valid),
        .push_chan  (push_chan),
        .push_flags (push_flags),
        .pop_en     (finish),
        .reappend   (finish && head_flags.refill),
        .head_chan  (head_chan),
        .head_flags (head_flags),
        .level      (q_level),
        .empty      (empty),
        .overflow   (overflow)
    );

    cq_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .trig_in    (trig_in),
        .head_valid (!empty),
        .head_wait  (head_flags.wait_trig),
        .busy       (busy),
        .consume    (finish),
        .trig_ok    (trig_ok)
    );

    cq_ctrl #(.CH_W(CH_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .req_valid   (req_valid),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .conv_abort  (conv_abort),
        .head_evt_en (head_flags.evt_en),
        .head_chan   (head_chan),
        .busy        (busy),
        .finish      (finish),
        .src_event   (src_event),
        .evt_chan    (evt_chan)
    );

    // Pending request: stored head, idle, gate open, trigger condition met.
    assign req_valid = !empty && !busy && gate_en && trig_ok;
    assign req_chan  = head_chan;

    assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> !req_valid);
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_level == '0) && !overflow && !req_valid);
    assert_abort_rerequest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_abort && !conv_done && !flush && gate_en) |=> req_valid);
endmodule

// File: tb/sim_conv_queue_src.sv
// Directed bench for conv_queue_src. Inputs change on the falling edge and
// outputs are sampled 2 ns later, well before the next rising edge.
module sim_conv_queue_src;
    localparam int CH_W  = 5;
    localparam int LVL_W = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic push_valid, push_refill, push_evt_en, push_wait_trig;
    logic [CH_W-1:0] push_chan;
    logic flush, trig_in, gate_en, conv_start, conv_done, conv_abort;
    logic req_valid, overflow, src_event;
    logic [CH_W-1:0] req_chan, evt_chan;
    logic [LVL_W-1:0] q_level;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    conv_queue_src u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_chan(push_chan),
        .push_refill(push_refill), .push_evt_en(push_evt_en),
        .push_wait_trig(push_wait_trig), .flush(flush), .trig_in(trig_in),
        .gate_en(gate_en), .conv_start(conv_start), .conv_done(conv_done),
        .conv_abort(conv_abort), .req_valid(req_valid), .req_chan(req_chan),
        .q_level(q_level), .overflow(overflow), .src_event(src_event),
        .evt_chan(evt_chan)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to the next sample point (falling edge + 2 ns).
    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic push(input int ch, input bit rf, input bit ev, input bit wt);
        @(negedge clk);
        push_valid = 1; push_chan = CH_W'(ch);
        push_refill = rf; push_evt_en = ev; push_wait_trig = wt;
        @(negedge clk);
        push_valid = 0;
        #2;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        #2;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1;
        @(negedge clk); trig_in = 0;
        #2;
    endtask

    // Serve the head entry: expect a request, start, finish, check the event.
    task automatic serve(input string req, input int ch, input bit ev);
        #0;
        check({req, " request pending"}, int'(req_valid), 1);
        check({req, " channel"}, int'(req_chan), ch);
        @(negedge clk); conv_start = 1;
        @(negedge clk); conv_start = 0; #2;
        check("R10 request drops while converting", int'(req_valid), 0);
        @(negedge clk); conv_done = 1;
        @(negedge clk); conv_done = 0; #2;
        check("R6 event pulse", int'(src_event), int'(ev));
        if (ev) check("R6 event channel", int'(evt_chan), ch);
        step();
        check("R6 event lasts one cycle", int'(src_event), 0);
    endtask

    task automatic t_reset();
        check("R12 level after reset", int'(q_level), 0);
        check("R12 no request after reset", int'(req_valid), 0);
        check("R12 no event after reset", int'(src_event), 0);
        check("R12 overflow clear after reset", int'(overflow), 0);
    endtask

    task automatic t_fifo_order();
        push(3, 0, 1, 0); push(5, 0, 0, 0); push(3, 0, 1, 0); push(0, 0, 0, 0);
        check("R1 level after four pushes", int'(q_level), 4);
        serve("R1", 3, 1);
        check("R5 level after plain completion", int'(q_level), 3);
        serve("R1", 5, 0);
        serve("R2 repeated channel", 3, 1);
        serve("R1", 0, 0);
        check("R5 level empty", int'(q_level), 0);
        check("R1 no request when empty", int'(req_valid), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) push(i + 20, 0, 0, 0);
        check("R3 level capped at 8", int'(q_level), 8);
        check("R3 overflow set", int'(overflow), 1);
        step();
        check("R3 overflow sticky", int'(overflow), 1);
        serve("R3 head kept", 20, 0);
        do_flush();
        check("R11 flush empties", int'(q_level), 0);
        check("R11 flush clears overflow", int'(overflow), 0);
        check("R11 no request after flush", int'(req_valid), 0);
    endtask

    task automatic t_refill();
        push(7, 1, 1, 0); push(2, 0, 0, 0);
        serve("R4 first pass", 7, 1);
        check("R4 level kept on refill", int'(q_level), 2);
        serve("R4 older entry next", 2, 0);
        check("R5 level after plain entry", int'(q_level), 1);
        serve("R4 refilled entry again", 7, 1);
        check("R4 level still one", int'(q_level), 1);
        do_flush();
    endtask

    task automatic t_trigger();
        pulse_trig();                 // empty queue: ignored
        push(4, 0, 0, 1);
        check("R8 trigger on empty not stored", int'(req_valid), 0);
        step(); step();
        check("R7 waits for trigger", int'(req_valid), 0);
        pulse_trig();
        check("R7 request after trigger", int'(req_valid), 1);
        serve("R7", 4, 0);
        push(1, 0, 0, 0); push(6, 0, 0, 1);
        pulse_trig();                 // head needs no trigger: ignored
        serve("R8 untriggered head", 1, 0);
        check("R8 trigger not kept for next head", int'(req_valid), 0);
        do_flush();
        push(9, 0, 0, 1);
        pulse_trig();
        do_flush();
        push(9, 0, 0, 1);
        check("R11 flush clears latched trigger", int'(req_valid), 0);
        do_flush();
    endtask

    task automatic t_gate();
        push(12, 0, 0, 1);
        @(negedge clk); gate_en = 0; #2;
        check("R9 gate closed blocks", int'(req_valid), 0);
        pulse_trig();
        check("R9 gate closed still blocks", int'(req_valid), 0);
        @(negedge clk); gate_en = 1; #2;
        check("R9 request after gate opens", int'(req_valid), 1);
        check("R9 channel", int'(req_chan), 12);
        do_flush();
    endtask

    task automatic t_abort();
        push(15, 0, 1, 1); push(16, 0, 0, 0);
        pulse_trig();
        @(negedge clk); conv_start = 1;
        @(negedge clk); conv_start = 0; #2;
        check("R10 busy hides request", int'(req_valid), 0);
        @(negedge clk); conv_abort = 1;
        @(negedge clk); conv_abort = 0; #2;
        check("R10 re-request after abort", int'(req_valid), 1);
        check("R10 same head after abort", int'(req_chan), 15);
        check("R10 level kept on abort", int'(q_level), 2);
        check("R6 no event on abort", int'(src_event), 0);
        serve("R10 retry", 15, 1);
        serve("R10 next", 16, 0);
        do_flush();
    endtask

    initial begin
        rst_n = 0; push_valid = 0; push_chan = '0; push_refill = 0;
        push_evt_en = 0; push_wait_trig = 0; flush = 0; trig_in = 0;
        gate_en = 1; conv_start = 0; conv_done = 0; conv_abort = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        t_reset();
        t_fifo_order();
        t_overflow();
        t_refill();
        t_trigger();
        t_gate();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule